// File: doc/BRIEF.md
# Five-Source Interrupt Prioritiser with Halt Control

This block sits next to an 8-bit CPU core. It collects five interrupt requests and keeps the global interrupt enable and a three-bit mask. Each clock edge it chooses at most one request by fixed priority. For the four internally vectored sources it pulses an acknowledge and presents a 16-bit service address. For the external source it pulses a separate external acknowledge, and outside logic then supplies the service routine.

The five sources, from highest to lowest priority, are:
- an unmaskable request, captured on its rising edge;
- three maskable levels called 7.5, 6.5 and 5.5, where 7.5 is captured on its rising edge and the other two follow their input levels;
- a general external request, which follows its input level.

The block also holds the core's halted flag. The flag is set by a halt request from the core and is cleared by reset or by any accepted interrupt. The core raises the enable-set or enable-clear strobe when it executes the matching instruction. It writes the mask through a strobe that carries the three mask bits and a clear bit for the 7.5 capture.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, all outputs are 0, the global enable is 0 and all three mask bits are 1, so every maskable line is blocked.
- R2: Priority, from highest to lowest, is unmaskable, 7.5, 6.5, 5.5, then external. The vectors are 0024h for unmaskable, 003Ch for 7.5, 0034h for 6.5 and 002Ch for 5.5. An accepted external request raises `ext_ack` with `vec` = 0 and leaves `ack` low.
- R3: A rising edge on `nmi_in` is captured. The capture is accepted whatever the enable and mask state, and acceptance clears it.
- R4: `mask_wr` loads `mask_wdata`: bit 2 masks 7.5, bit 1 masks 6.5 and bit 0 masks 5.5. A bit value of 1 blocks the line.
- R5: The 7.5, 6.5, 5.5 and external sources are accepted only while the global enable is 1. `ien_set` sets the enable and `ien_clr` clears it; clear wins when both are raised.
- R6: Accepting a 7.5, 6.5, 5.5 or external request clears the global enable. Accepting the unmaskable request leaves the enable unchanged.
- R7: A rising edge on `r75_in` is captured regardless of mask and enable. The capture is cleared when it is accepted, or by `mask_wr` with `clr75` = 1. An edge in the same cycle as a clear leaves the capture set.
- R8: `r65_in`, `r55_in` and `ext_req` are level sensitive. A request that drops before it is eligible leaves no trace.
- R9: `ack` and `ext_ack` are registered outputs. Each goes high for the one cycle after the edge that accepts a request. `vec` is 0 whenever `ack` is low.
- R10: `halt_req` sets `halted`. Any acceptance clears `halted`, and an acceptance in the same cycle as `halt_req` leaves `halted` at 0.
- R11: While the global enable is 0, a raised unmasked maskable line neither wakes the core nor produces an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_in | input | 1 | Unmaskable request, edge captured |
| r75_in | input | 1 | Maskable level 7.5, edge captured |
| r65_in | input | 1 | Maskable level 6.5, level sensitive |
| r55_in | input | 1 | Maskable level 5.5, level sensitive |
| ext_req | input | 1 | External request, level sensitive |
| ien_set | input | 1 | Strobe that sets the global enable |
| ien_clr | input | 1 | Strobe that clears the global enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 3 | Mask bits {7.5, 6.5, 5.5} |
| clr75 | input | 1 | With `mask_wr`, clears the 7.5 capture |
| halt_req | input | 1 | Core enters the halted state |
| ack | output | 1 | One-cycle acknowledge for an internally vectored source |
| vec | output | VEC_W | Service address while `ack` is high, else 0 |
| ext_ack | output | 1 | One-cycle acknowledge for the external request |
| halted | output | 1 | Core is halted |
| int_en | output | 1 | Global enable state |

## Verification
Two pairs of events can land in the same cycle, and the bench drives each pair on purpose.

The first pair is a halt request and an acceptance. The bench raises `halt_req` on the same edge where an unmasked 5.5 request is accepted. It expects `halted` to read 0 and `ack` to carry 002Ch.

The second pair is a clear of the 7.5 capture and a new 7.5 edge. The bench raises `r75_in` in the cycle of a `mask_wr` with `clr75` = 1. It then enables interrupts and expects 003Ch to be acknowledged two edges later.

The priority order is covered by sweeping all 64 combinations of the five sources and the enable bit, and then all 8 mask values.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Source slots in the request vector, higher index = higher priority
    localparam int SRC_N   = 5;
    localparam int SRC_NMI = 4;
    localparam int SRC_R75 = 3;
    localparam int SRC_R65 = 2;
    localparam int SRC_R55 = 1;
    localparam int SRC_EXT = 0;
    localparam int MASK_W  = 3;

    // Service address: restart level times 8 (level 4.5 for the unmaskable one)
    function automatic logic [15:0] slot_vector(input int slot);
        int half_lvl;
        case (slot)
            SRC_NMI: half_lvl = 9;
            SRC_R75: half_lvl = 15;
            SRC_R65: half_lvl = 13;
            SRC_R55: half_lvl = 11;
            default: half_lvl = 0;
        endcase
        return 16'(half_lvl * 4);
    endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } el_t;

    el_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = din;
        // a fresh edge outranks a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | (din & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              r75_in,
    input  logic              r65_in,
    input  logic              r55_in,
    input  logic              ext_req,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              clr75,
    input  logic              halt_req,
    output logic              ack,
    output logic [VEC_W-1:0]  vec,
    output logic              ext_ack,
    output logic              halted,
    output logic              int_en
);
    typedef struct packed {
        logic              ien;
        logic [MASK_W-1:0] mask;
        logic              halted;
        logic              ack;
        logic              ext_ack;
        logic [VEC_W-1:0]  vec;
    } arb_t;

    arb_t st_d, st_q;

    logic             nmi_pend, r75_pend;
    logic [SRC_N-1:0] req_w, grant_w;
    logic             any_grant, gated_grant;
    logic [MASK_W-1:0] mask_q;

    // capture latches for the two edge-sensitive sources
    irq_edge_latch u_nmi_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (nmi_in),
        .clr  (grant_w[SRC_NMI]),
        .pend (nmi_pend)
    );

    irq_edge_latch u_r75_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (r75_in),
        .clr  (grant_w[SRC_R75] | (mask_wr & clr75)),
        .pend (r75_pend)
    );

    // eligibility per source
    always_comb begin
        req_w          = '0;
        req_w[SRC_NMI] = nmi_pend;
        req_w[SRC_R75] = r75_pend & ~st_q.mask[2] & st_q.ien;
        req_w[SRC_R65] = r65_in   & ~st_q.mask[1] & st_q.ien;
        req_w[SRC_R55] = r55_in   & ~st_q.mask[0] & st_q.ien;
        req_w[SRC_EXT] = ext_req  & st_q.ien;
    end

    irq_prio_pick #(.N(SRC_N)) u_pick (
        .req  (req_w),
        .grant(grant_w)
    );

    assign any_grant   = |grant_w;
    assign gated_grant = |grant_w[SRC_R75:SRC_EXT];

    always_comb begin
        st_d         = st_q;
        st_d.ien     = (st_q.ien | ien_set) & ~ien_clr & ~gated_grant;
        if (mask_wr) st_d.mask = mask_wdata;
        if (any_grant)     st_d.halted = 1'b0;
        else if (halt_req) st_d.halted = 1'b1;
        st_d.ack     = |grant_w[SRC_NMI:SRC_R55];
        st_d.ext_ack = grant_w[SRC_EXT];
        st_d.vec     = '0;
        for (int s = SRC_R55; s <= SRC_NMI; s++) begin
            if (grant_w[s]) st_d.vec = VEC_W'(slot_vector(s));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q  = st_q.mask;
    assign ack     = st_q.ack;
    assign vec     = st_q.vec;
    assign ext_ack = st_q.ext_ack;
    assign halted  = st_q.halted;
    assign int_en  = st_q.ien;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             r65_in,
    input logic             ext_req,
    input logic             ack,
    input logic [VEC_W-1:0] vec,
    input logic             ext_ack,
    input logic             halted,
    input logic             int_en,
    input logic [2:0]       mask_q
);
    a_r9_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack, ext_ack}));

    a_r2_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (vec == VEC_W'(16'h0024) || vec == VEC_W'(16'h003C) ||
                 vec == VEC_W'(16'h0034) || vec == VEC_W'(16'h002C)));

    a_r9_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (vec == '0));

    a_r6_ext_drops_ien: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |-> !int_en);

    a_r6_mask_drops_ien: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vec != VEC_W'(16'h0024)) |-> !int_en);

    a_r10_wake_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || ext_ack) |-> !halted);

    a_r4_mask65_open: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vec == VEC_W'(16'h0034)) |-> $past(!mask_q[1] && r65_in));

    a_r5_ext_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |-> $past(int_en && ext_req));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .r65_in (r65_in),
    .ext_req(ext_req),
    .ack    (ack),
    .vec    (vec),
    .ext_ack(ext_ack),
    .halted (halted),
    .int_en (int_en),
    .mask_q (mask_q)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        nmi_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, ext_req = 0;
    logic        ien_set = 0, ien_clr = 0, mask_wr = 0, clr75 = 0, halt_req = 0;
    logic [2:0]  mask_wdata = 3'b000;
    logic        ack, ext_ack, halted, int_en;
    logic [15:0] vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .r75_in(r75_in),
        .r65_in(r65_in), .r55_in(r55_in), .ext_req(ext_req),
        .ien_set(ien_set), .ien_clr(ien_clr), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .clr75(clr75), .halt_req(halt_req),
        .ack(ack), .vec(vec), .ext_ack(ext_ack), .halted(halted), .int_en(int_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drop every request, open the mask, clear enable and 7.5 capture
    task automatic quiesce();
        nmi_in = 0; r75_in = 0; r65_in = 0; r55_in = 0; ext_req = 0;
        halt_req = 0; ien_set = 0;
        mask_wr = 1; mask_wdata = 3'b000; clr75 = 1; ien_clr = 1;
        tick();
        mask_wr = 0; clr75 = 0; ien_clr = 0;
        tick();
        tick();
    endtask

    task automatic enable();
        ien_set = 1;
        tick();
        ien_set = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ev;
        logic        ea, ex, eien;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ack", ack, 0);
        chk("R1 ext_ack", ext_ack, 0);
        chk("R1 vec", vec, 0);
        chk("R1 halted", halted, 0);
        chk("R1 int_en", int_en, 0);
        rst_n = 1;
        tick();
        // R1: all masked after reset, so 5.5 ignored even when enabled
        enable();
        r55_in = 1;
        tick();
        chk("R1 masked 5.5 ack", ack, 0);
        chk("R1 masked 5.5 int_en", int_en, 1);
        quiesce();

        // R2 R3 R5 R6 R8: sweep of sources and enable
        for (int c = 0; c < 64; c++) begin
            quiesce();
            if (c[5]) enable();
            nmi_in = c[4]; r75_in = c[3];
            tick();
            r65_in = c[2]; r55_in = c[1]; ext_req = c[0];
            tick();
            ea = 0; ex = 0; ev = 16'h0000; eien = c[5];
            if (c[4]) begin ea = 1; ev = 16'h0024; end
            else if (c[5]) begin
                if (c[3])      begin ea = 1; ev = 16'h003C; eien = 0; end
                else if (c[2]) begin ea = 1; ev = 16'h0034; eien = 0; end
                else if (c[1]) begin ea = 1; ev = 16'h002C; eien = 0; end
                else if (c[0]) begin ex = 1; eien = 0; end
            end
            chk($sformatf("R2 sweep %0d ack", c), ack, ea);
            chk($sformatf("R2 sweep %0d vec", c), vec, ev);
            chk($sformatf("R5 sweep %0d ext_ack", c), ext_ack, ex);
            chk($sformatf("R6 sweep %0d int_en", c), int_en, eien);
        end

        // R4: mask sweep with every source but the unmaskable one raised
        for (int m = 0; m < 8; m++) begin
            quiesce();
            mask_wr = 1; mask_wdata = 3'(m); ien_set = 1;
            tick();
            mask_wr = 0; ien_set = 0;
            r75_in = 1;
            tick();
            r65_in = 1; r55_in = 1; ext_req = 1;
            tick();
            ea = 1; ex = 0;
            if (!m[2])      ev = 16'h003C;
            else if (!m[1]) ev = 16'h0034;
            else if (!m[0]) ev = 16'h002C;
            else begin ea = 0; ex = 1; ev = 16'h0000; end
            chk($sformatf("R4 mask %0d ack", m), ack, ea);
            chk($sformatf("R4 mask %0d vec", m), vec, ev);
            chk($sformatf("R4 mask %0d ext_ack", m), ext_ack, ex);
        end

        // R10 R11: halt, ignored maskable while disabled, unmaskable wakes
        quiesce();
        halt_req = 1;
        tick();
        halt_req = 0;
        chk("R10 halted set", halted, 1);
        r65_in = 1;
        tick();
        tick();
        chk("R11 still halted", halted, 1);
        chk("R11 no ack", ack, 0);
        nmi_in = 1;
        tick();
        tick();
        chk("R3 nmi ack while disabled", ack, 1);
        chk("R3 nmi vec", vec, 16'h0024);
        chk("R10 woken", halted, 0);
        chk("R6 nmi keeps enable", int_en, 0);

        // R10: halt request in the cycle of an acceptance
        quiesce();
        enable();
        halt_req = 1; r55_in = 1;
        tick();
        halt_req = 0;
        chk("R10 same cycle halted", halted, 0);
        chk("R10 same cycle vec", vec, 16'h002C);

        // R7: 7.5 pulse while disabled is remembered
        quiesce();
        r75_in = 1;
        tick();
        r75_in = 0;
        tick();
        enable();
        chk("R7 no ack before enable seen", ack, 0);
        tick();
        chk("R7 latched ack", ack, 1);
        chk("R7 latched vec", vec, 16'h003C);

        // R7: clear bit removes the capture
        quiesce();
        r75_in = 1;
        tick();
        r75_in = 0;
        mask_wr = 1; clr75 = 1;
        tick();
        mask_wr = 0; clr75 = 0;
        enable();
        tick();
        chk("R7 cleared no ack", ack, 0);
        chk("R7 cleared int_en", int_en, 1);

        // R7: edge in the same cycle as a clear survives
        quiesce();
        r75_in = 1; mask_wr = 1; clr75 = 1;
        tick();
        mask_wr = 0; clr75 = 0;
        enable();
        tick();
        chk("R7 collision vec", vec, 16'h003C);

        // R8: short level pulse before enable leaves no trace
        quiesce();
        r55_in = 1;
        tick();
        r55_in = 0;
        tick();
        enable();
        tick();
        chk("R8 dropped level ack", ack, 0);
        chk("R8 dropped level int_en", int_en, 1);

        // R9: external acknowledge is a single-cycle pulse
        quiesce();
        enable();
        ext_req = 1;
        tick();
        chk("R9 ext_ack high", ext_ack, 1);
        chk("R9 ext vec zero", vec, 0);
        tick();
        chk("R9 ext_ack pulse ends", ext_ack, 0);
        ext_req = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule